// File: doc/BRIEF.md
# Addressed SPI Port Expander

This block is an SPI slave that drives one 8-bit general-purpose pin port from a small register file. A host clocks frames in SPI mode 0 (clock idles low, data sampled on the rising edge, shifted out on the falling edge). Each frame starts with a command byte, then a register pointer byte, then any number of data bytes. Data bytes carry write values on MOSI, or return read values on MISO. Up to eight expanders can share one chip select. A 3-bit address in the command byte, matched against strap inputs, selects the one that answers.

The register file holds the pin direction, input inversion, pull-up setting, output latch and configuration. It also holds the registers of a change-detect interrupt unit. That unit flags enabled pins that change, or that differ from a reference value, and captures the port state at that moment. The serial lines and the pins are oversampled on the system clock through two-flop synchronisers. The host's serial clock must therefore stay well below the system clock.

Top module: `spi_gpio_expander`

## Requirements
- R1: After reset, direction is 0xFF (all pins inputs, `pin_oe` = 0x00). Every other register reads 0x00, `pin_out` is 0x00, `spi_miso_oe` is 0 and `irq` is 1 (inactive, active-low).
- R2: Command byte bits [7:4] must be 4'b0100. Bits [3:1] hold the target address and bit 0 selects read (1) or write (0). Byte two is the register pointer. Registers: 0x00 direction, 0x01 input inversion, 0x02 interrupt enable, 0x03 reference value, 0x04 compare select, 0x05 configuration, 0x06 pull-up, 0x07 flag, 0x08 capture, 0x09 port, 0x0A output latch. Writable registers read back the value last written.
- R3: When configuration bit 3 (address check) is 0, any command address is accepted. When it is 1, only a command whose bits [3:1] equal `strap_addr` is served. A frame with any other address changes nothing and never drives MISO.
- R4: When configuration bit 5 is 0, the pointer advances after every data byte and wraps from 0x0A to 0x00. When bit 5 is 1, every data byte of the frame goes to the same register.
- R5: `pin_oe` is the inverse of the direction register (a 0 bit drives the pin). `pin_out` follows the output latch. Writes to pointer 0x09 and to 0x0A both load the latch.
- R6: Reading 0x09 returns the synchronised pin levels XOR the input inversion register.
- R7: Reads of pointers above 0x0A return 0x00. Writes to 0x07, to 0x08 and to any pointer above 0x0A are ignored. Configuration bits 7 and 4 always read 0.
- R8: Raising chip select part-way through a byte discards that byte. The next frame starts from its command byte.
- R9: `spi_miso_oe` is 1 only while the device is selected and addressed in a read frame and past the pointer byte.
- R10: An enabled pin with compare select 0 raises its flag when its port value changes. With compare select 1, it raises its flag when its port value differs from the reference bit. While any flag is set, no new flags are taken. The capture register holds the port value at the moment the flags were taken.
- R11: The flags clear once a data byte read from 0x08 (configuration bit 0 = 1) or from 0x09 (bit 0 = 0) has been fully shifted out. `irq` is `|flags` when configuration bit 1 is 1 and its inverse when bit 1 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Drive enable for MISO (0 = released) |
| strap_addr | input | 3 | Hardware address straps |
| pin_in | input | 8 | Pin levels (asynchronous) |
| pin_out | output | 8 | Output latch value to the pads |
| pin_oe | output | 8 | Pad drive enables |
| irq | output | 1 | Interrupt, polarity set by configuration bit 1 |

## Verification
On every cycle, the assertions check that chip-select release clears the frame state, that MISO is driven only in an addressed read data phase, and that the pointer wraps at 0x0A. They also check that ignored write targets leave the writable registers unchanged and that flags hold until a clearing read. Only the bench scenarios can show the end-to-end effects at the ports. These are address filtering with the check on and off, burst ordering with and without increment, inverted port reads, discarded partial bytes, and the interrupt sequence with its two compare modes, two clear sources and two polarities.

// File: rtl/spi_gpio_expander.sv
module spi_gpio_expander #(
  parameter logic [3:0] OP_PREFIX = 4'h4,
  parameter logic [7:0] LAST_REG  = 8'h0A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_sck,
  input  logic       spi_cs_n,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic [2:0] strap_addr,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic       irq
);
  localparam logic [7:0] CFG_MASK = 8'h6F;

  logic [2:0] sck_p, cs_p, mosi_p;
  logic [7:0] pin_m, pin_s, port_prev;
  logic [2:0] bit_cnt;
  logic [6:0] rx;
  logic [1:0] phase;
  logic       hit, rd;
  logic [7:0] ptr, tx;
  logic       miso_q;
  logic [7:0] dir_q, inv_q, ien_q, ref_q, csel_q, cfg_q, pull_q, flag_q, cap_q, olat_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p <= '0; cs_p <= '1; mosi_p <= '0; pin_m <= '0; pin_s <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], spi_sck};
      cs_p   <= {cs_p[1:0], spi_cs_n};
      mosi_p <= {mosi_p[1:0], spi_mosi};
      pin_m  <= pin_in;
      pin_s  <= pin_m;
    end

  wire       sel       = ~cs_p[1];
  wire       sck_rise  = sck_p[1] & ~sck_p[2];
  wire       sck_fall  = ~sck_p[1] & sck_p[2];
  wire [7:0] byte_in   = {rx, mosi_p[1]};
  wire       byte_done = sel & sck_rise & (bit_cnt == 3'd7);
  wire       op_ok     = (byte_in[7:4] == OP_PREFIX) & (~cfg_q[3] | (byte_in[3:1] == strap_addr));
  wire [7:0] ptr_inc   = (ptr == LAST_REG) ? 8'h00 : ptr + 8'h01;
  wire [7:0] ptr_nxt   = (phase == 2'd1) ? byte_in : (cfg_q[5] ? ptr : ptr_inc);
  wire       data_done = byte_done & (phase == 2'd2) & hit;
  wire       wr_en     = data_done & ~rd;
  wire       clr_flag  = data_done & rd & (ptr == (cfg_q[0] ? 8'h08 : 8'h09));
  wire       load_tx   = byte_done & (phase != 2'd0) & hit & rd;
  wire [7:0] port_val  = pin_s ^ inv_q;
  wire [7:0] change    = ien_q & ((csel_q & (port_val ^ ref_q)) | (~csel_q & (port_val ^ port_prev)));

  logic [7:0] rd_data;
  always_comb
    case (ptr_nxt)
      8'h00: rd_data = dir_q;
      8'h01: rd_data = inv_q;
      8'h02: rd_data = ien_q;
      8'h03: rd_data = ref_q;
      8'h04: rd_data = csel_q;
      8'h05: rd_data = cfg_q;
      8'h06: rd_data = pull_q;
      8'h07: rd_data = flag_q;
      8'h08: rd_data = cap_q;
      8'h09: rd_data = port_val;
      8'h0A: rd_data = olat_q;
      default: rd_data = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0; rx <= '0; phase <= '0; hit <= 1'b0; rd <= 1'b0;
      ptr <= '0; tx <= '0; miso_q <= 1'b0;
    end else if (!sel) begin
      bit_cnt <= '0; phase <= '0; hit <= 1'b0; rd <= 1'b0;
    end else if (sck_rise) begin
      rx      <= byte_in[6:0];
      bit_cnt <= bit_cnt + 3'd1;
      if (bit_cnt == 3'd7) begin
        if (phase == 2'd0) begin
          hit   <= op_ok;
          rd    <= byte_in[0];
          phase <= 2'd1;
        end else begin
          ptr   <= ptr_nxt;
          phase <= 2'd2;
        end
        if (load_tx) tx <= rd_data;
      end
    end else if (sck_fall) begin
      miso_q <= tx[7];
      tx     <= {tx[6:0], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= 8'hFF; inv_q <= '0; ien_q <= '0; ref_q <= '0; csel_q <= '0;
      cfg_q <= '0; pull_q <= '0; olat_q <= '0;
    end else if (wr_en) begin
      case (ptr)
        8'h00: dir_q  <= byte_in;
        8'h01: inv_q  <= byte_in;
        8'h02: ien_q  <= byte_in;
        8'h03: ref_q  <= byte_in;
        8'h04: csel_q <= byte_in;
        8'h05: cfg_q  <= byte_in & CFG_MASK;
        8'h06: pull_q <= byte_in;
        8'h09, 8'h0A: olat_q <= byte_in;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_q <= '0; cap_q <= '0; port_prev <= '0;
    end else begin
      port_prev <= port_val;
      if (clr_flag) flag_q <= '0;
      else if (flag_q == 8'h00 && change != 8'h00) begin
        flag_q <= change;
        cap_q  <= port_val;
      end
    end

  assign spi_miso    = miso_q;
  assign spi_miso_oe = sel & hit & rd & (phase == 2'd2);
  assign pin_out     = olat_q;
  assign pin_oe      = ~dir_q;
  assign irq         = cfg_q[1] ? |flag_q : ~|flag_q;

  p_release_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_p[1]) |=> (phase == 2'd0 && bit_cnt == 3'd0 && !spi_miso_oe));

  p_oe_only_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> (rd && hit && !cs_p[1]));

  p_pointer_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_done && ptr == LAST_REG && !cfg_q[5]) |=> (ptr == 8'h00));

  p_ignored_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ptr == 8'h07 || ptr == 8'h08 || ptr > LAST_REG)) |=>
      ($stable(dir_q) && $stable(olat_q) && $stable(cfg_q) && $stable(ien_q)));

  p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != 8'h00 && !clr_flag) |=> $stable(flag_q) && $stable(cap_q));

  p_flag_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flag |=> (flag_q == 8'h00));
endmodule

// File: tb/spi_gpio_expander_bench.sv
module spi_gpio_expander_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, spi_sck, spi_cs_n, spi_mosi;
  logic       spi_miso, spi_miso_oe, irq;
  logic [2:0] strap_addr;
  logic [7:0] pin_in, pin_out, pin_oe;

  spi_gpio_expander u_spi_gpio_expander (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .strap_addr(strap_addr), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq(irq));

  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;

  int checks = 0, errors = 0;
  logic [7:0] m [0:10];
  logic [7:0] wbuf [0:15];
  logic [7:0] rbuf [0:15];
  logic       oe_seen;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic spi_byte(input logic [7:0] d, output logic [7:0] r, input int nbits);
    r = 8'h00;
    for (int i = 7; i >= 8 - nbits; i--) begin
      spi_mosi = d[i];
      half();
      r[i] = spi_miso;
      if (spi_miso_oe) oe_seen = 1'b1;
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic frame(input bit rd, input logic [2:0] a3, input logic [7:0] ra, input int n);
    logic [7:0] dummy;
    oe_seen = 1'b0;
    spi_cs_n = 1'b0;
    half();
    spi_byte({4'h4, a3, rd}, dummy, 8);
    spi_byte(ra, dummy, 8);
    for (int k = 0; k < n; k++) spi_byte(rd ? 8'h00 : wbuf[k], rbuf[k], 8);
    half();
    spi_cs_n = 1'b1;
    half(); half();
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] a);
    if (m[5][5]) return a;
    return (a == 8'h0A) ? 8'h00 : a + 8'h01;
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h09 || a == 8'h0A) m[10] = d;
    else if (a == 8'h05) m[5] = d & 8'h6F;
    else if (a <= 8'h06) m[a[3:0]] = d;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a > 8'h0A) return 8'h00;
    if (a == 8'h09) return pin_in ^ m[1];
    return m[a[3:0]];
  endfunction

  task automatic wr(input logic [7:0] ra, input int n);
    logic [7:0] a, na;
    a = ra;
    for (int k = 0; k < n; k++) begin
      na = nxt(a);
      mwrite(a, wbuf[k]);
      a = na;
    end
    frame(1'b0, STRAP, ra, n);
  endtask

  task automatic wr1(input logic [7:0] ra, input logic [7:0] d);
    wbuf[0] = d;
    wr(ra, 1);
  endtask

  task automatic rchk(input string req, input logic [7:0] ra, input int n);
    logic [7:0] a;
    frame(1'b1, STRAP, ra, n);
    a = ra;
    for (int k = 0; k < n; k++) begin
      chk(req, rbuf[k], exp_rd(a));
      a = nxt(a);
    end
  endtask

  task automatic rd1(input logic [7:0] ra);
    frame(1'b1, STRAP, ra, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] dummy, a;
    int n;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    strap_addr = STRAP; pin_in = 8'h00;
    m[0] = 8'hFF;
    for (int i = 1; i <= 10; i++) m[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 miso_oe", {7'd0, spi_miso_oe}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h01);
    rchk("R1 regs", 8'h00, 11);

    // R2 basic write and readback
    wr1(8'h00, 8'hF0);
    chk("R2/R5 pin_oe", pin_oe, 8'h0F);
    rchk("R2 dir readback", 8'h00, 1);
    wr1(8'h06, 8'h5A);
    rchk("R2 pullup readback", 8'h06, 1);

    // R9 write frame never drives MISO; read data does
    frame(1'b0, STRAP, 8'h03, 1);
    chk("R9 no drive in write", {7'd0, oe_seen}, 8'h00);
    rd1(8'h03);
    chk("R9 drive in read", {7'd0, oe_seen}, 8'h01);
    chk("R9 released after", {7'd0, spi_miso_oe}, 8'h00);

    // R3 address check off: any address served
    wbuf[0] = 8'h3C;
    frame(1'b0, 3'b010, 8'h0A, 1);
    m[10] = 8'h3C;
    chk("R3 any address when check off", pin_out, 8'h3C);
    wr1(8'h05, 8'h08);
    wbuf[0] = 8'hC3;
    frame(1'b0, 3'b010, 8'h0A, 1);
    chk("R3 mismatched write ignored", pin_out, 8'h3C);
    frame(1'b1, 3'b011, 8'h05, 2);
    chk("R3 mismatched read silent", {7'd0, oe_seen}, 8'h00);
    rchk("R3 matched read", 8'h05, 1);

    // R4 burst with wrap
    wr1(8'h0A, 8'h81);
    rchk("R4 wrap burst", 8'h09, 5);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr(8'h0A, 3);
    chk("R4 wrap write hits dir", pin_oe, ~8'h22);
    wr1(8'h05, 8'h28);
    wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
    wr(8'h0A, 3);
    chk("R4 no increment latch", pin_out, 8'h66);
    chk("R4 no increment dir kept", pin_oe, ~8'h22);
    rchk("R4 no increment read", 8'h00, 3);
    wr1(8'h05, 8'h08);

    // R5/R2 random bursts (interrupt enable kept 0)
    for (int it = 0; it < 30; it++) begin
      a = 8'($urandom_range(0, 10));
      n = $urandom_range(1, 4);
      begin
        logic [7:0] p;
        p = a;
        for (int k = 0; k < n; k++) begin
          wbuf[k] = (p == 8'h02) ? 8'h00 : 8'($urandom);
          p = nxt(p);
        end
      end
      wr(a, n);
      chk("R5 latch", pin_out, m[10]);
      chk("R5 enables", pin_oe, ~m[0]);
      rchk("R2 random readback", a, n);
    end
    wr1(8'h05, 8'h08);

    // R6 inverted port read
    pin_in = 8'hA5;
    wr1(8'h01, 8'h0F);
    rd1(8'h09);
    chk("R6 port inverted", rbuf[0], 8'hAA);

    // R7 out-of-range and read-only targets
    rchk("R7 above range", 8'h0B, 1);
    rd1(8'h20);
    chk("R7 far above range", rbuf[0], 8'h00);
    wr1(8'h07, 8'hFF);
    rd1(8'h07);
    chk("R7 flag not writable", rbuf[0], 8'h00);
    wr1(8'h08, 8'hFF);
    rd1(8'h08);
    chk("R7 capture not writable", rbuf[0], 8'h00);
    wr1(8'h0C, 8'h00);
    rchk("R7 dir untouched by 0x0C", 8'h00, 1);
    wr1(8'h05, 8'hFF);
    rd1(8'h05);
    chk("R7 config bits 7,4 zero", rbuf[0], 8'h6F);
    wr1(8'h05, 8'h08);

    // R8 partial byte discarded
    wr1(8'h0A, 8'h0F);
    spi_cs_n = 1'b0; half();
    spi_byte({4'h4, STRAP, 1'b0}, dummy, 8);
    spi_byte(8'h0A, dummy, 8);
    spi_byte(8'hF0, dummy, 5);
    half(); spi_cs_n = 1'b1; half(); half();
    chk("R8 partial byte dropped", pin_out, 8'h0F);
    wr1(8'h0A, 8'h96);
    chk("R8 next frame clean", pin_out, 8'h96);

    // R10/R11 change detect
    pin_in = 8'h00;
    wr1(8'h01, 8'h00);
    wr1(8'h04, 8'h00);
    wr1(8'h05, 8'h00);
    rd1(8'h09);
    rd1(8'h08);
    wr1(8'h02, 8'h01);
    chk("R11 idle irq high", {7'd0, irq}, 8'h01);
    pin_in = 8'h01;
    repeat (10) @(negedge clk);
    chk("R11 irq active low", {7'd0, irq}, 8'h00);
    pin_in = 8'h03;
    repeat (10) @(negedge clk);
    rd1(8'h07);
    chk("R10 flag", rbuf[0], 8'h01);
    rd1(8'h08);
    chk("R10 capture frozen", rbuf[0], 8'h01);
    chk("R11 capture read keeps flag (bit0=0)", {7'd0, irq}, 8'h00);
    rd1(8'h09);
    chk("R11 port read clears", {7'd0, irq}, 8'h01);
    wr1(8'h05, 8'h03);
    chk("R11 active high idle", {7'd0, irq}, 8'h00);
    pin_in = 8'h02;
    repeat (10) @(negedge clk);
    chk("R11 active high fires", {7'd0, irq}, 8'h01);
    rd1(8'h09);
    chk("R11 port read keeps flag (bit0=1)", {7'd0, irq}, 8'h01);
    rd1(8'h08);
    chk("R10 capture on fall", rbuf[0], 8'h02);
    chk("R11 capture read clears", {7'd0, irq}, 8'h00);
    wr1(8'h03, 8'h00);
    wr1(8'h04, 8'h01);
    repeat (10) @(negedge clk);
    chk("R10 equal to reference no flag", {7'd0, irq}, 8'h00);
    pin_in = 8'h03;
    repeat (10) @(negedge clk);
    chk("R10 differs from reference", {7'd0, irq}, 8'h01);
    rd1(8'h07);
    chk("R10 reference flag", rbuf[0], 8'h01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule